// File: doc/BRIEF.md
# Byte-Order-Selectable Load/Store Unit

This block sits between a small integer core and a byte-addressable data memory that is 32 bits wide and answers within the same cycle. On each request it adds a sign-extended 12-bit displacement to a base register value to form the access address. This base-plus-displacement sum is the only address form. A load picks a byte, halfword or word out of the memory word and extends it to 32 bits. A store copies its data into every lane the access could use and drives a byte-enable mask that covers only the bytes it writes.

A static mode pin sets the byte order inside each word: least significant byte at the lowest address, or most significant byte at the lowest address. The memory word is held in numeric order, so bits 8k+7:8k form lane k. The mode therefore only changes which lane a byte or halfword access hits. A whole aligned word passes through unchanged in either mode. An access whose address does not match its size raises a misalignment flag and is dropped. Load results come back from a register one cycle after the request, together with a valid strobe.

Top module: `lsu_endian`

## Requirements
- R1: The access address is the base plus the 12-bit displacement sign-extended. `mem_addr_o` is that address with bits 1:0 cleared.
- R2: For a byte access with address bits 1:0 equal to `o`, the lane is `o` in little-endian mode (`big_endian_i`=0) and `3-o` in big-endian mode (`big_endian_i`=1). Lane k is bits 8k+7:8k of the memory word.
- R3: A halfword access uses bits 15:0 of the memory word when the address has bit 1 clear, and bits 31:16 when bit 1 is set. In big-endian mode the two halves are swapped.
- R4: Load funct3 codes are 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte and 101 unsigned halfword. Signed loads copy the top bit of the item into all upper bits. Unsigned loads fill the upper bits with zeros. A word load returns the memory word unchanged.
- R5: Store funct3 codes are 000 byte, 001 halfword and 010 word, and bit 2 is ignored on stores. A byte store drives all four lanes with the byte and enables only the lane given by R2. A halfword store drives both halves with the halfword and enables only the two lanes given by R3.
- R6: A word store enables all four lanes and writes the data unchanged in either mode. A word stored and then loaded from the same address comes back identical.
- R7: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, raises `misalign_o` in that cycle. That access drives no byte enables and no write strobe, and it produces no load result.
- R8: An accepted load raises `load_valid_o` and presents its result on `load_data_o` one cycle after the request. In every other cycle `load_valid_o` is low and `load_data_o` holds its previous value.
- R9: `mem_we_o` is high only in the cycle of an accepted store. A load never asserts it.
- R10: Asserting `rst_n` low clears `load_valid_o` and `load_data_o` at once. The release of reset passes through two flops before it takes effect.
- R11: A funct3 whose low two bits are 11 performs no access. It drives no enables, no write strobe and no load result, and it does not raise `misalign_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | Static byte order: 1 puts the most significant byte at the lowest address |
| req_valid_i | input | 1 | A request is present this cycle |
| req_store_i | input | 1 | 1 for a store, 0 for a load |
| req_funct3_i | input | 3 | Access size and extension code |
| base_i | input | 32 | Base register value |
| offset_i | input | 12 | Signed displacement |
| store_data_i | input | 32 | Store data, right-aligned |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_be_o | output | 4 | Per-lane byte enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Memory word read at `mem_addr_o` in the same cycle |
| misalign_o | output | 1 | Current request is misaligned |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The bench sweeps both byte orders over every load code, every store code and every byte offset inside a word. A design with the lane inversion missing would return the opposite end of the word for a big-endian byte load. One that mixed up the halves would swap the halfwords. Sign extension is checked on the patterns 0xEF and 0xDE, where copying the wrong bit gives 0x000000EF instead of 0xFFFFFFEF. Misaligned halfword and word cases are checked for a flag with silent enables and a load register that keeps its value. A design that still wrote, or still loaded, would corrupt memory or the result. A negative displacement checks that the immediate is sign-extended and not zero-extended.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NLANES = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(NLANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } acc_size_e;

  // Byte offset within the word to the numeric lane that holds it
  function automatic logic [LANE_W-1:0] byte_lane(input logic [LANE_W-1:0] off,
                                                  input logic big);
    return big ? ~off : off;
  endfunction

  // Halfword offset bit to the numeric half that holds it
  function automatic logic half_sel(input logic off_hi, input logic big);
    return big ? ~off_hi : off_hi;
  endfunction
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o,
  output logic              size_ok_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign ea_o    = base_i + imm_ext;

  always_comb begin
    misalign_o = 1'b0;
    size_ok_o  = 1'b1;
    case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = ea_o[0];
      SZ_WORD: misalign_o = |ea_o[1:0];
      default: size_ok_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic              en_i,
  input  logic              big_i,
  input  logic [LANE_W-1:0] off_i,
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NLANES-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [LANE_W-1:0] lane;
  logic              half;

  assign lane = byte_lane(off_i, big_i);
  assign half = half_sel(off_i[LANE_W-1], big_i);

  always_comb begin
    be_o    = '0;
    wdata_o = '0;
    if (en_i) begin
      case (size_i)
        SZ_BYTE: begin
          be_o[lane] = 1'b1;
          wdata_o    = {NLANES{data_i[7:0]}};
        end
        SZ_HALF: begin
          be_o    = 4'b0011 << {half, 1'b0};
          wdata_o = {(NLANES/2){data_i[15:0]}};
        end
        SZ_WORD: begin
          be_o    = '1;
          wdata_o = data_i;
        end
        default: begin
          be_o    = '0;
          wdata_o = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic              big_i,
  input  logic [LANE_W-1:0] off_i,
  input  acc_size_e         size_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] value_o
);
  logic [LANE_W-1:0] lane;
  logic              half;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;

  assign lane   = byte_lane(off_i, big_i);
  assign half   = half_sel(off_i[LANE_W-1], big_i);
  assign byte_v = rdata_i[{lane, 3'b000} +: 8];
  assign half_v = rdata_i[{half, 4'b0000} +: 16];

  always_comb begin
    case (size_i)
      SZ_BYTE: value_o = unsigned_i ? {24'h0, byte_v} : {{24{byte_v[7]}}, byte_v};
      SZ_HALF: value_o = unsigned_i ? {16'h0, half_v} : {{16{half_v[15]}}, half_v};
      default: value_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_endian.sv
module lsu_endian
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [2:0]        req_funct3_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [NLANES-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misalign_o,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o
);
  logic              rst_q_n;
  acc_size_e         size;
  logic [ADDR_W-1:0] ea;
  logic              mis;
  logic              size_ok;
  logic              accept;
  logic              store_en;
  logic              load_en;
  logic [DATA_W-1:0] ext_val;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;

  assign size = acc_size_e'(req_funct3_i[1:0]);

  lsu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .base_i     (base_i),
    .imm_i      (offset_i),
    .size_i     (size),
    .ea_o       (ea),
    .misalign_o (mis),
    .size_ok_o  (size_ok)
  );

  assign accept   = req_valid_i && size_ok && !mis;
  assign store_en = accept && req_store_i;
  assign load_en  = accept && !req_store_i;

  lsu_store_lanes u_st (
    .en_i    (store_en),
    .big_i   (big_endian_i),
    .off_i   (ea[LANE_W-1:0]),
    .size_i  (size),
    .data_i  (store_data_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  lsu_load_extract u_ld (
    .big_i      (big_endian_i),
    .off_i      (ea[LANE_W-1:0]),
    .size_i     (size),
    .unsigned_i (req_funct3_i[2]),
    .rdata_i    (mem_rdata_i),
    .value_o    (ext_val)
  );

  assign mem_addr_o = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_we_o   = store_en;
  assign misalign_o = req_valid_i && mis;

  // next state
  always_comb begin
    valid_d = load_en;
    data_d  = data_q;
    if (load_en) data_d = ext_val;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) data_q <= data_d;
    end
  end

  assign load_valid_o = valid_q;
  assign load_data_o  = data_q;

  assert_misalign_silent_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    misalign_o |-> (mem_be_o == '0 && !mem_we_o));

  assert_we_needs_store_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we_o |-> (req_store_i && mem_be_o != '0));

  assert_valid_after_load_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_valid_o |-> $past(req_valid_i && !req_store_i));

  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load_valid_o |-> $stable(load_data_o));

  assert_word_full_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_we_o && req_funct3_i[1:0] == 2'b10) |-> (mem_be_o == '1 && mem_wdata_o == store_data_i));

  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_we_o && req_funct3_i[1:0] == 2'b00) |-> ($countones(mem_be_o) == 1));

  assert_bad_size_quiet_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_funct3_i[1:0] == 2'b11) |-> (!misalign_o && !mem_we_o && mem_be_o == '0));
endmodule

// File: tb/lsu_endian_test.sv
module lsu_endian_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        big;
  logic        req_valid, req_store;
  logic [2:0]  f3;
  logic [31:0] base;
  logic [11:0] off;
  logic [31:0] sdata;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
  logic        mem_we, misalign, load_valid;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails  = 0;

  logic [31:0] bmem [4];
  logic [3:0]  s_be;
  logic [31:0] s_wd, s_addr, s_data, last_load;
  logic        s_we, s_mis, s_valid;

  always #5 clk = ~clk;

  lsu_endian uut (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big),
    .req_valid_i(req_valid), .req_store_i(req_store), .req_funct3_i(f3),
    .base_i(base), .offset_i(off), .store_data_i(sdata),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .misalign_o(misalign), .load_valid_o(load_valid), .load_data_o(load_data)
  );

  assign mem_rdata = bmem[mem_addr[3:2]];

  always_ff @(posedge clk) begin
    if (mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) bmem[mem_addr[3:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [2:0] code, input logic [31:0] b,
                        input logic [11:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; f3 = code; base = b; off = o; sdata = d;
    #1;
    s_be = mem_be; s_wd = mem_wdata; s_we = mem_we; s_mis = misalign; s_addr = mem_addr;
    @(posedge clk);
    #1;
    s_valid = load_valid; s_data = load_data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] o,
                                           input logic bg, input logic [2:0] code);
    logic [1:0]  lane;
    logic        h;
    logic [7:0]  bv;
    logic [15:0] hv;
    lane = bg ? 2'd3 - o : o;
    h    = bg ? ~o[1] : o[1];
    bv   = w[8*lane +: 8];
    hv   = w[16*h +: 16];
    case (code)
      3'b000:  return {{24{bv[7]}}, bv};
      3'b100:  return {24'h0, bv};
      3'b001:  return {{16{hv[15]}}, hv};
      3'b101:  return {16'h0, hv};
      default: return w;
    endcase
  endfunction

  function automatic logic aligned(input logic [2:0] code, input logic [1:0] o);
    case (code[1:0])
      2'b00:   return 1'b1;
      2'b01:   return !o[0];
      2'b10:   return o == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] lcodes [5];
    lcodes[0] = 3'b000; lcodes[1] = 3'b001; lcodes[2] = 3'b010;
    lcodes[3] = 3'b100; lcodes[4] = 3'b101;
    bmem[0] = 32'hDEADBEEF; bmem[1] = 32'h80017FFE;
    bmem[2] = 32'h7F80FF01; bmem[3] = 32'h12345678;
    rst_n = 1'b0; big = 1'b0; req_valid = 1'b0; req_store = 1'b0;
    f3 = 3'b0; base = '0; off = '0; sdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", {31'h0, load_valid}, 32'h0);
    chk("R10 reset data", load_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    last_load = 32'h0;

    // loads: both orders, all codes, all offsets, all words
    for (int bg = 0; bg < 2; bg++) begin
      big = bg[0];
      for (int ci = 0; ci < 5; ci++)
        for (int wi = 0; wi < 4; wi++)
          for (int o = 0; o < 4; o++) begin
            logic [31:0] w;
            w = bmem[wi];
            access(1'b0, lcodes[ci], 32'h100 + 32'(4*wi), 12'(o), 32'h0);
            chk("R9 load no write", {31'h0, s_we}, 32'h0);
            if (aligned(lcodes[ci], o[1:0])) begin
              chk(lcodes[ci][1:0] == 2'b00 ? "R2 R4 byte load" :
                  lcodes[ci][1:0] == 2'b01 ? "R3 R4 half load" : "R6 R4 word load",
                  s_data, exp_load(w, o[1:0], bg[0], lcodes[ci]));
              chk("R8 load valid", {31'h0, s_valid}, 32'h1);
              last_load = s_data;
            end else begin
              chk("R7 misalign flag", {31'h0, s_mis}, 32'h1);
              chk("R7 no load result", {31'h0, s_valid}, 32'h0);
              chk("R8 data held", s_data, last_load);
            end
          end
    end

    // stores: enables and replicated data
    for (int bg = 0; bg < 2; bg++) begin
      big = bg[0];
      for (int c = 0; c < 3; c++)
        for (int o = 0; o < 4; o++) begin
          logic [31:0] d;
          logic [3:0]  ebe;
          logic [31:0] ewd;
          logic [1:0]  lane;
          logic        h;
          d = 32'hA1B2C3D4 ^ 32'(o * 32'h01010101);
          lane = bg[0] ? 2'd3 - 2'(o) : 2'(o);
          h = bg[0] ? ~o[1] : o[1];
          case (c)
            0: begin ebe = 4'b0001 << lane; ewd = {4{d[7:0]}}; end
            1: begin ebe = h ? 4'b1100 : 4'b0011; ewd = {2{d[15:0]}}; end
            default: begin ebe = 4'b1111; ewd = d; end
          endcase
          access(1'b1, 3'(c) | 3'b100, 32'h10C, 12'(o), d);
          if (aligned(3'(c), o[1:0])) begin
            chk(c == 2 ? "R6 word store be" : "R5 store be", {28'h0, s_be}, {28'h0, ebe});
            chk(c == 2 ? "R6 word store data" : "R5 store data", s_wd, ewd);
            chk("R9 store write", {31'h0, s_we}, 32'h1);
          end else begin
            chk("R7 misalign flag", {31'h0, s_mis}, 32'h1);
            chk("R7 no enables", {28'h0, s_be}, 32'h0);
            chk("R7 no write", {31'h0, s_we}, 32'h0);
          end
          chk("R8 store no valid", {31'h0, s_valid}, 32'h0);
          chk("R8 store data held", s_data, last_load);
        end
    end

    // word round trip and byte order of a known word
    for (int bg = 0; bg < 2; bg++) begin
      big = bg[0];
      access(1'b1, 3'b010, 32'h104, 12'h0, 32'hDEADBEEF);
      access(1'b0, 3'b010, 32'h104, 12'h0, 32'h0);
      chk("R6 round trip", s_data, 32'hDEADBEEF);
      access(1'b0, 3'b100, 32'h104, 12'h0, 32'h0);
      chk("R2 low address byte", s_data, bg ? 32'h000000DE : 32'h000000EF);
      access(1'b0, 3'b100, 32'h104, 12'h3, 32'h0);
      chk("R2 high address byte", s_data, bg ? 32'h000000EF : 32'h000000DE);
      access(1'b0, 3'b000, 32'h104, 12'h0, 32'h0);
      chk("R4 signed byte", s_data, bg ? 32'hFFFFFFDE : 32'hFFFFFFEF);
      last_load = s_data;
    end

    // address generation
    big = 1'b0;
    access(1'b0, 3'b010, 32'h110, 12'hFF0, 32'h0);
    chk("R1 negative displacement", s_addr, 32'h100);
    chk("R1 negative displacement data", s_data, bmem[0]);
    access(1'b0, 3'b000, 32'h1000, 12'h7FF, 32'h0);
    chk("R1 positive displacement", s_addr, 32'h17FC);
    last_load = s_data;

    // unused size code
    access(1'b1, 3'b011, 32'h100, 12'h0, 32'hFFFFFFFF);
    chk("R11 no enables", {28'h0, s_be}, 32'h0);
    chk("R11 no write", {31'h0, s_we}, 32'h0);
    chk("R11 no flag", {31'h0, s_mis}, 32'h0);
    access(1'b0, 3'b111, 32'h100, 12'h0, 32'h0);
    chk("R11 no load result", {31'h0, s_valid}, 32'h0);
    chk("R11 data held", s_data, last_load);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule